// File: doc/BRIEF.md
# Enable-Qualified Prescaled Dual Timer

This block holds two down-counting timer channels that share one timer clock. Each channel has its own clock-enable strobe, prescaler, counter and sticky interrupt flag. A channel's count rate is gated twice. Its enable strobe first selects which timer-clock edges count. Its prescaler then passes only one of every N of those qualified edges on to the counter.

All control is driven directly on ports. Per channel there is a load strobe with its value, a run control, a prescale select, a free-running mode select and an interrupt clear strobe. The timer clock is expected to be derived so that its rising edges line up with the system bus clock and never run faster than it. Any register access sits outside this block.

Top module: `dualPrescaleTimer`

## Requirements
- R1: While `rstN` is low, every channel's `count` is 0, its `irq` is 0 and its prescaler is at 0.
- R2: The channels are independent: a channel whose `tickEn` bit is low holds its `count`, whatever the other channel does.
- R3: With `preSel` = 0 (divide by 1), `run` high and `tickEn` held high, `count` drops by one on every rising clock edge.
- R4: A counter tick that finds `count` at 0 sets `irq` and, with `freeRun` low, reloads `count` from the last loaded value.
- R5: An `irqClr` pulse clears `irq` on the next edge, and it wins over a set in the same cycle.
- R6: A `loadWr` pulse makes `count` equal `loadVal` after the next edge and restarts the channel's prescaler, even when `tickEn` or `run` is low.
- R7: While `run` is low, the channel's `count` and prescaler hold and its `irq` does not set.
- R8: With divide by 1 and `tickEn` high on every second edge only, `count` drops on every second edge.
- R9: The `preSel` encoding is 0 for divide by 1, 1 for divide by 16, and 2 or 3 for divide by 256. After a load, the first counter tick comes on the Nth qualified edge, and later ticks come every N qualified edges.
- R10: With `freeRun` high, a tick at `count` 0 sets `irq` and wraps `count` to all ones instead of reloading.
- R11: Once set, `irq` stays high until an `irqClr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | NUM_CH | Per-channel clock-enable strobe |
| run | input | NUM_CH | Per-channel run control |
| preSel | input | NUM_CH x 2 | Per-channel prescale select |
| freeRun | input | NUM_CH | Per-channel wrap mode (1 = wrap to all ones) |
| loadWr | input | NUM_CH | Per-channel load strobe |
| loadVal | input | NUM_CH x CNT_W | Per-channel load value |
| irqClr | input | NUM_CH | Per-channel interrupt clear strobe |
| count | output | NUM_CH x CNT_W | Per-channel counter value |
| irq | output | NUM_CH | Per-channel sticky interrupt flag |

## Verification
Loads, clears and divide-by-1 decrements show at the ports one rising edge after the cycle in which their inputs are driven. A prescaled decrement shows on the Nth qualified edge after a load. Every expected value is queued with the cycle in which it is due, and a monitor compares it at the falling edge of that cycle. The long prescaled waits are checked both at the last edge before the decrement and at the edge that makes it, which pins the tick to its exact cycle.

// File: rtl/tmrPkg.sv
package tmrPkg;
  // Strobes sent from a channel's control to its datapath each cycle.
  typedef struct packed {
    logic restart; // load value written: take it now
    logic step;    // qualified prescaler tick: advance the counter
  } tmrStrobe_t;

  typedef enum logic [1:0] {
    SEL_DIV1    = 2'd0,
    SEL_DIVMID  = 2'd1,
    SEL_DIVHI   = 2'd2,
    SEL_DIVHI_B = 2'd3
  } preSel_e;
endpackage

// File: rtl/tmrPrescaleCtl.sv
module tmrPrescaleCtl
  import tmrPkg::*;
#(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 256,
  parameter int PRE_W   = $clog2(DIV_HI)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       qualEn,
  input  logic       runEn,
  input  logic       loadWr,
  input  logic [1:0] preSel,
  output tmrStrobe_t strobe
);
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] preTerm;
  logic             advance;

  always_comb begin
    case (preSel_e'(preSel))
      SEL_DIV1:   preTerm = '0;
      SEL_DIVMID: preTerm = PRE_W'(DIV_MID - 1);
      default:    preTerm = PRE_W'(DIV_HI - 1);
    endcase
  end

  assign advance = runEn && qualEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pre <= '0;
    end else if (loadWr) begin
      pre <= preTerm;
    end else if (advance) begin
      if (pre == '0) pre <= preTerm;
      else           pre <= pre - 1'b1;
    end
  end

  assign strobe.restart = loadWr;
  assign strobe.step    = !loadWr && advance && (pre == '0);
endmodule

// File: rtl/tmrCountPath.sv
module tmrCountPath
  import tmrPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] loadVal,
  input  logic             freeRun,
  input  logic             irqClr,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reloadReg;
  logic             irqFlag;
  logic             atZero;
  logic             setIrq;

  assign atZero = (cnt == '0);
  assign setIrq = strobe.step && atZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      reloadReg <= '0;
    end else if (strobe.restart) begin
      cnt       <= loadVal;
      reloadReg <= loadVal;
    end else if (strobe.step) begin
      if (atZero) cnt <= freeRun ? '1 : reloadReg;
      else        cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       irqFlag <= 1'b0;
    else if (irqClr) irqFlag <= 1'b0;
    else if (setIrq) irqFlag <= 1'b1;
  end

  assign count = cnt;
  assign irq   = irqFlag;
endmodule

// File: rtl/dualPrescaleTimer.sv
module dualPrescaleTimer
  import tmrPkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int CNT_W   = 16,
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 256
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CH-1:0]             tickEn,
  input  logic [NUM_CH-1:0]             run,
  input  logic [NUM_CH-1:0][1:0]        preSel,
  input  logic [NUM_CH-1:0]             freeRun,
  input  logic [NUM_CH-1:0]             loadWr,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  loadVal,
  input  logic [NUM_CH-1:0]             irqClr,
  output logic [NUM_CH-1:0][CNT_W-1:0]  count,
  output logic [NUM_CH-1:0]             irq
);
  localparam int PRE_W = $clog2(DIV_HI);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    tmrStrobe_t strobe;

    tmrPrescaleCtl #(
      .DIV_MID(DIV_MID),
      .DIV_HI (DIV_HI),
      .PRE_W  (PRE_W)
    ) u_ctl (
      .clk   (clk),
      .rstN  (rstN),
      .qualEn(tickEn[ch]),
      .runEn (run[ch]),
      .loadWr(loadWr[ch]),
      .preSel(preSel[ch]),
      .strobe(strobe)
    );

    tmrCountPath #(
      .CNT_W(CNT_W)
    ) u_path (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobe),
      .loadVal(loadVal[ch]),
      .freeRun(freeRun[ch]),
      .irqClr (irqClr[ch]),
      .count  (count[ch]),
      .irq    (irq[ch])
    );
  end
endmodule

// File: rtl/dualPrescaleTimerChk.sv
module dualPrescaleTimerChk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NUM_CH-1:0]            tickEn,
  input logic [NUM_CH-1:0]            run,
  input logic [NUM_CH-1:0]            loadWr,
  input logic [NUM_CH-1:0][CNT_W-1:0] loadVal,
  input logic [NUM_CH-1:0]            irqClr,
  input logic [NUM_CH-1:0][CNT_W-1:0] count,
  input logic [NUM_CH-1:0]            irq
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    a_r2_enable_gates: assert property (@(posedge clk) disable iff (!rstN)
      (!loadWr[c] && !tickEn[c]) |=> $stable(count[c]));

    a_r7_run_low_holds: assert property (@(posedge clk) disable iff (!rstN)
      (!loadWr[c] && !run[c] && !irq[c]) |=> (!irq[c] && $stable(count[c])));

    a_r4_irq_from_zero: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irq[c]) |-> ($past(count[c]) == '0));

    a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
      irqClr[c] |=> !irq[c]);

    a_r6_load_takes: assert property (@(posedge clk) disable iff (!rstN)
      loadWr[c] |=> (count[c] == $past(loadVal[c])));

    a_r11_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (irq[c] && !irqClr[c]) |=> irq[c]);
  end
endmodule

bind dualPrescaleTimer dualPrescaleTimerChk #(
  .NUM_CH(NUM_CH),
  .CNT_W (CNT_W)
) i_chk (.*);

// File: tb/test_dualPrescaleTimer.sv
module test_dualPrescaleTimer;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 2;
  localparam int CNT_W  = 16;

  logic                         clk = 1'b0;
  logic                         rstN;
  logic [NUM_CH-1:0]            tickEn;
  logic [NUM_CH-1:0]            run;
  logic [NUM_CH-1:0][1:0]       preSel;
  logic [NUM_CH-1:0]            freeRun;
  logic [NUM_CH-1:0]            loadWr;
  logic [NUM_CH-1:0][CNT_W-1:0] loadVal;
  logic [NUM_CH-1:0]            irqClr;
  logic [NUM_CH-1:0][CNT_W-1:0] count;
  logic [NUM_CH-1:0]            irq;

  dualPrescaleTimer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_dualPrescaleTimer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .run(run), .preSel(preSel),
    .freeRun(freeRun), .loadWr(loadWr), .loadVal(loadVal), .irqClr(irqClr),
    .count(count), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int             due;
    int             ch;
    logic [CNT_W-1:0] cnt;
    logic           irqExp;
    string          tag;
  } expItem_t;

  expItem_t sbQ[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares due expectations at the falling edge.
  always @(negedge clk) begin
    while (sbQ.size() > 0 && sbQ[0].due <= cyc) begin
      expItem_t it;
      it = sbQ.pop_front();
      checks++;
      if (count[it.ch] !== it.cnt || irq[it.ch] !== it.irqExp) begin
        errors++;
        $display("FAIL %s ch%0d: count=%0d irq=%0b, expected count=%0d irq=%0b",
                 it.tag, it.ch, count[it.ch], irq[it.ch], it.cnt, it.irqExp);
      end
    end
  end

  // Driver helpers.
  task automatic expectNow(int ch, logic [CNT_W-1:0] c, logic i, string tag);
    expItem_t it;
    it.due = cyc; it.ch = ch; it.cnt = c; it.irqExp = i; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic loadCh(int ch, logic [CNT_W-1:0] v);
    loadWr[ch] = 1'b1;
    loadVal[ch] = v;
    tick();
    loadWr[ch] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; tickEn = '0; run = '0; preSel = '0; freeRun = '0;
    loadWr = '0; loadVal = '0; irqClr = '0;
    tick(3);
    expectNow(0, 0, 0, "R1 reset");
    expectNow(1, 0, 0, "R1 reset");
    tick();
    rstN = 1'b1;

    loadCh(0, 5);
    expectNow(0, 5, 0, "R6 load ch0");
    loadCh(1, 9);
    expectNow(1, 9, 0, "R6 load ch1");

    // R7: enabled but not running
    tickEn = 2'b11; run = 2'b00;
    tick(3);
    expectNow(0, 5, 0, "R7 run low holds");
    expectNow(1, 9, 0, "R7 run low holds");

    // R3 and R2: ch0 counts every edge, ch1 has enable low
    run = 2'b11; tickEn = 2'b01;
    for (int k = 1; k <= 5; k++) begin
      tick();
      expectNow(0, CNT_W'(5 - k), 0, "R3 div1 decrement");
      expectNow(1, 9, 0, "R2 other channel held");
    end
    tick();
    expectNow(0, 5, 1, "R4 zero tick reload and irq");
    tick();
    expectNow(0, 4, 1, "R11 irq sticky");
    tick(2);
    expectNow(0, 2, 1, "R11 irq sticky");
    irqClr[0] = 1'b1;
    tick();
    irqClr[0] = 1'b0;
    expectNow(0, 1, 0, "R5 clear");
    tick();
    expectNow(0, 0, 0, "R3 reach zero");
    irqClr[0] = 1'b1;
    tick();
    irqClr[0] = 1'b0;
    expectNow(0, 5, 0, "R5 clear beats set");

    // R8: enable on every second edge
    for (int i = 0; i < 4; i++) begin
      tickEn[0] = i[0];
      tick();
      expectNow(0, (i < 1) ? 5 : (i < 3) ? 4 : 3, 0, "R8 half-rate enable");
    end
    run[0] = 1'b0;

    // R9: divide by 16 on ch1
    preSel[1] = 2'd1; tickEn[1] = 1'b1; run[1] = 1'b1;
    loadCh(1, 2);
    expectNow(1, 2, 0, "R6 load ch1");
    tick(15);
    expectNow(1, 2, 0, "R9 div16 before tick");
    tick();
    expectNow(1, 1, 0, "R9 div16 tick");

    // R6: load restarts the prescaler even with enable low
    tick(5);
    tickEn[1] = 1'b0;
    loadCh(1, 7);
    expectNow(1, 7, 0, "R6 load with enable low");
    tickEn[1] = 1'b1;
    tick(15);
    expectNow(1, 7, 0, "R6 prescaler restarted");
    tick();
    expectNow(1, 6, 0, "R6 prescaler restarted");

    // R9: divide by 256
    preSel[1] = 2'd2;
    loadCh(1, 1);
    tick(255);
    expectNow(1, 1, 0, "R9 div256 before tick");
    tick();
    expectNow(1, 0, 0, "R9 div256 tick");

    // R10: free-running wrap
    preSel[1] = 2'd0; freeRun[1] = 1'b1;
    loadCh(1, 0);
    expectNow(1, 0, 0, "R10 load zero");
    tick();
    expectNow(1, 16'hFFFF, 1, "R10 wrap to all ones");
    tick();
    expectNow(1, 16'hFFFE, 1, "R10 keeps counting");
    expectNow(0, 3, 0, "R7 stopped channel holds");

    tick(2);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule